// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by walking a two-level table in memory. The walk uses a single-word read port. The walker raises `mem_req` with an address and holds both until the memory answers with `mem_valid` and a data word.

The first level is a directory with 4096 word entries. Its base comes from a configuration register. A valid directory entry points to a second-level table with 256 word entries. Each second-level entry maps one 4 KB page and carries a 4-bit access-control index. The walker returns the translated address and that index with a one-cycle `rsp_done` pulse.

When a directory entry or a page entry is invalid, the walker ends the request with `rsp_fault`. It then sets a per-level sticky status bit, captures the faulting virtual address for that level and raises `irq`. While translation is switched off, requests come straight back untranslated.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_done`, `mem_req`, `irq`, every bit of `fault_status` and both error-address outputs are 0. Translation is disabled and the table base is 0.
- R2: While the enable bit is 0, an accepted request produces `rsp_done` one cycle later with `rsp_pa` equal to the request address, `rsp_fault` 0 and `rsp_aci` 0, and no memory read is issued.
- R3: With the enable bit at 1, the first read goes to table base + 4 × VA[31:20]. `mem_req` and `mem_addr` stay unchanged until `mem_valid` is seen.
- R4: A directory entry is valid only when its bits 1:0 are exactly 01. Any other value (00, 10 or 11) ends the walk after that single read, with `rsp_fault` 1, status bit 16 set and `err_va_l1` loaded with the virtual address. No second read is issued.
- R5: The second read goes to (directory entry AND 0xFFFFFC00) + 4 × VA[19:12]. Bits 9:2 of the directory entry have no effect on it.
- R6: A page entry is valid when its bit 1 is 1. The walker then returns `rsp_pa` = {entry[31:12], VA[11:0]} and `rsp_aci` = entry[7:4], with `rsp_fault` 0.
- R7: A page entry with bit 1 at 0 ends the walk with `rsp_fault` 1, sets status bit 17 and loads `err_va_l2` with the virtual address. Status bit 16 is not set.
- R8: `irq` is 1 whenever status bit 16 or 17 is 1. Writing to configuration offset 0x04 clears status bit 16 when data bit 16 is 1 and status bit 17 when data bit 17 is 1.
- R9: Only one translation is in flight at a time. `req_ready` is 0 from the cycle after acceptance until the walk ends, and `rsp_done` lasts exactly one cycle. A fully successful walk with one-cycle memory answers ends four cycles after acceptance; a first-level fault ends two cycles after acceptance.
- R10: A write to offset 0x50 sets the table base, and bit 0 of a write to offset 0x20 sets the enable. Writes to any other offset change neither.
- R11: While a level's status bit is set, a later fault at that level keeps the captured address of the first fault. After the bit is cleared, the next fault is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, accepts a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_done | output | 1 | One-cycle end-of-walk pulse |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_pa | output | 32 | Translated physical address |
| rsp_aci | output | 4 | Access-control index of the page entry |
| mem_req | output | 1 | Table read request, held until answered |
| mem_addr | output | 32 | Byte address of the table word |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table word |
| fault_status | output | 32 | Sticky fault bits: 16 first level, 17 second level |
| err_va_l1 | output | 32 | Captured address of a first-level fault |
| err_va_l2 | output | 32 | Captured address of a second-level fault |
| irq | output | 1 | Interrupt while any fault bit is set |

## Verification
Every result has a fixed cycle count once the memory answers one cycle after each request. A pass-through ends one cycle after acceptance, a first-level fault two cycles after, and a successful walk or a second-level fault four cycles after. The bench counts falling edges from the acceptance edge and checks that `rsp_done` appears at exactly that count. It then samples the result, status and capture outputs on that same falling edge, where the registered state has settled. A separate memory model logs each read address and counts reads. This shows that a first-level fault issues one read and that pass-through issues none.

// File: rtl/walk_pkg.sv
`timescale 1ns/1ps
package walk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIR  = 2'd1,
      ST_PTE  = 2'd2,
      ST_RESP = 2'd3
   } walk_state_e;

   localparam int unsigned LVL_N      = 2;
   localparam int unsigned LVL_DIR    = 0;
   localparam int unsigned LVL_PTE    = 1;
   localparam int unsigned STAT_DIR_B = 16;
   localparam int unsigned STAT_PTE_B = 17;
endpackage

// File: rtl/walk_cfg.sv
`timescale 1ns/1ps
module walk_cfg #(
   parameter int unsigned AW       = 32,
   parameter int unsigned CA_W     = 12,
   parameter int unsigned OFF_EN   = 12'h020,
   parameter int unsigned OFF_BASE = 12'h050,
   parameter int unsigned OFF_CLR  = 12'h004
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [CA_W-1:0]              addr,
   input  logic [AW-1:0]                wdata,
   output logic [AW-1:0]                tbl_base,
   output logic                         xlate_en,
   output logic [walk_pkg::LVL_N-1:0]   clr
);
   import walk_pkg::*;

   localparam logic [CA_W-1:0] A_EN   = CA_W'(OFF_EN);
   localparam logic [CA_W-1:0] A_BASE = CA_W'(OFF_BASE);
   localparam logic [CA_W-1:0] A_CLR  = CA_W'(OFF_CLR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_base <= '0;
         xlate_en <= 1'b0;
      end else if (we) begin
         if (addr == A_BASE) tbl_base <= wdata;
         if (addr == A_EN)   xlate_en <= wdata[0];
      end
   end

   always_comb begin
      clr = '0;
      if (we && addr == A_CLR) begin
         clr[LVL_DIR] = wdata[STAT_DIR_B];
         clr[LVL_PTE] = wdata[STAT_PTE_B];
      end
   end
endmodule

// File: rtl/walk_fsm.sv
`timescale 1ns/1ps
module walk_fsm #(
   parameter int unsigned AW      = 32,
   parameter int unsigned L1_BITS = 12,
   parameter int unsigned L2_BITS = 8,
   parameter int unsigned ACI_LSB = 4,
   parameter int unsigned ACI_W   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [AW-1:0]               tbl_base,
   input  logic                        xlate_en,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [AW-1:0]               req_va,
   output logic                        rsp_done,
   output logic                        rsp_fault,
   output logic [AW-1:0]               rsp_pa,
   output logic [ACI_W-1:0]            rsp_aci,
   output logic                        mem_req,
   output logic [AW-1:0]               mem_addr,
   input  logic                        mem_valid,
   input  logic [AW-1:0]               mem_rdata,
   output logic [walk_pkg::LVL_N-1:0]  flt_evt,
   output logic [AW-1:0]               flt_va
);
   import walk_pkg::*;

   localparam int unsigned ENT_LG2 = 2;
   localparam int unsigned OFF_W   = AW - L1_BITS - L2_BITS;
   localparam int unsigned L2_LSB  = OFF_W;
   localparam int unsigned L1_LSB  = OFF_W + L2_BITS;
   localparam int unsigned PT_LSB  = L2_BITS + ENT_LG2;
   localparam logic [AW-1:0] PT_MASK = ~((AW'(1) << PT_LSB) - AW'(1));

   walk_state_e           st_q;
   logic [AW-1:0]         va_q, pt_q, pa_q;
   logic [ACI_W-1:0]      aci_q;
   logic                  flt_q;
   logic [L1_BITS-1:0]    idx1;
   logic [L2_BITS-1:0]    idx2;
   logic                  dir_ok, pte_ok;

   assign idx1   = va_q[L1_LSB +: L1_BITS];
   assign idx2   = va_q[L2_LSB +: L2_BITS];
   assign dir_ok = (mem_rdata[1:0] == 2'b01);
   assign pte_ok = mem_rdata[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         va_q  <= '0;
         pt_q  <= '0;
         pa_q  <= '0;
         aci_q <= '0;
         flt_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q  <= req_va;
               flt_q <= 1'b0;
               aci_q <= '0;
               if (xlate_en) begin
                  pa_q <= '0;
                  st_q <= ST_DIR;
               end else begin
                  pa_q <= req_va;
                  st_q <= ST_RESP;
               end
            end
            ST_DIR: if (mem_valid) begin
               if (dir_ok) begin
                  pt_q <= mem_rdata & PT_MASK;
                  st_q <= ST_PTE;
               end else begin
                  flt_q <= 1'b1;
                  st_q  <= ST_RESP;
               end
            end
            ST_PTE: if (mem_valid) begin
               if (pte_ok) begin
                  pa_q  <= {mem_rdata[AW-1:OFF_W], va_q[OFF_W-1:0]};
                  aci_q <= mem_rdata[ACI_LSB +: ACI_W];
               end else begin
                  flt_q <= 1'b1;
               end
               st_q <= ST_RESP;
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (st_q == ST_IDLE);
      mem_req   = (st_q == ST_DIR) || (st_q == ST_PTE);
      if (st_q == ST_PTE) mem_addr = pt_q + (AW'(idx2) << ENT_LG2);
      else                mem_addr = tbl_base + (AW'(idx1) << ENT_LG2);
      rsp_done  = (st_q == ST_RESP);
      rsp_fault = flt_q;
      rsp_pa    = pa_q;
      rsp_aci   = aci_q;
      flt_evt          = '0;
      flt_evt[LVL_DIR] = (st_q == ST_DIR) && mem_valid && !dir_ok;
      flt_evt[LVL_PTE] = (st_q == ST_PTE) && mem_valid && !pte_ok;
      flt_va    = va_q;
   end

   // R9: a done pulse never stretches to a second cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R9: accepting a request closes the door to the next one
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R3: an unanswered read keeps its request and address
   a_r3_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
   // R4: a first-level fault never leads to a second read
   a_r4_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
      flt_evt[LVL_DIR] |=> (!mem_req && rsp_done && rsp_fault));
endmodule

// File: rtl/walk_faults.sv
`timescale 1ns/1ps
module walk_faults #(
   parameter int unsigned AW         = 32,
   parameter int unsigned NLVL       = 2,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NLVL-1:0]           evt,
   input  logic [AW-1:0]             evt_va,
   input  logic [NLVL-1:0]           clr,
   output logic [NLVL-1:0]           flag,
   output logic [NLVL-1:0][AW-1:0]   err_va
);
   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      always_ff @(posedge clk) begin
         if (!rst_n)      flag[g] <= 1'b0;
         else if (evt[g]) flag[g] <= 1'b1;
         else if (clr[g]) flag[g] <= 1'b0;
      end

      if (KEEP_FIRST) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n)                            err_va[g] <= '0;
            else if (evt[g] && (!flag[g] || clr[g])) err_va[g] <= evt_va;
         end
         // R11: a held capture is not overwritten by a later fault
         a_r11_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clr[g]) |=> $stable(err_va[g]));
      end else begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n)      err_va[g] <= '0;
            else if (evt[g]) err_va[g] <= evt_va;
         end
      end

      // R4 / R7: every fault event leaves its status bit set
      a_r4_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
         evt[g] |=> flag[g]);
      // R8: a bit only rises because of a fault event
      a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[g]) |-> $past(evt[g]));
   end
endmodule

// File: rtl/iova_walker.sv
`timescale 1ns/1ps
module iova_walker #(
   parameter int unsigned AW         = 32,
   parameter int unsigned CA_W       = 12,
   parameter int unsigned L1_BITS    = 12,
   parameter int unsigned L2_BITS    = 8,
   parameter int unsigned ACI_LSB    = 4,
   parameter int unsigned ACI_W      = 4,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CA_W-1:0]   cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_va,
   output logic              rsp_done,
   output logic              rsp_fault,
   output logic [31:0]       rsp_pa,
   output logic [ACI_W-1:0]  rsp_aci,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_valid,
   input  logic [31:0]       mem_rdata,
   output logic [31:0]       fault_status,
   output logic [31:0]       err_va_l1,
   output logic [31:0]       err_va_l2,
   output logic              irq
);
   import walk_pkg::*;

   if (AW != 32) begin : g_bad_aw
      $error("iova_walker: address width must be 32");
   end
   if (L1_BITS + L2_BITS >= AW) begin : g_bad_split
      $error("iova_walker: index fields leave no page offset");
   end
   if (ACI_LSB + ACI_W > AW - L1_BITS - L2_BITS) begin : g_bad_aci
      $error("iova_walker: access index overlaps the page frame");
   end

   logic [AW-1:0]            tbl_base;
   logic                     xlate_en;
   logic [LVL_N-1:0]         clr, evt, flag;
   logic [AW-1:0]            evt_va;
   logic [LVL_N-1:0][AW-1:0] err_va;

   walk_cfg #(.AW(AW), .CA_W(CA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .tbl_base(tbl_base), .xlate_en(xlate_en), .clr(clr)
   );

   walk_fsm #(.AW(AW), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
              .ACI_LSB(ACI_LSB), .ACI_W(ACI_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .xlate_en(xlate_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
      .rsp_aci(rsp_aci), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .flt_evt(evt), .flt_va(evt_va)
   );

   walk_faults #(.AW(AW), .NLVL(LVL_N), .KEEP_FIRST(KEEP_FIRST)) u_flt (
      .clk(clk), .rst_n(rst_n), .evt(evt), .evt_va(evt_va), .clr(clr),
      .flag(flag), .err_va(err_va)
   );

   always_comb begin
      fault_status             = '0;
      fault_status[STAT_DIR_B] = flag[LVL_DIR];
      fault_status[STAT_PTE_B] = flag[LVL_PTE];
      err_va_l1                = err_va[LVL_DIR];
      err_va_l2                = err_va[LVL_PTE];
      irq                      = |flag;
   end

   // R7: a faulted walk leaves a status bit behind at its done pulse
   a_r7_fault_has_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_fault) |-> (irq && (fault_status[STAT_DIR_B] || fault_status[STAT_PTE_B])));
   // R2: a walk that never read memory reports no fault
   a_r2_no_fault_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !$past(mem_req)) |-> !rsp_fault);
endmodule

// File: tb/iova_walker_tb.sv
`timescale 1ns/1ps
module iova_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        rsp_done, rsp_fault;
   logic [31:0] rsp_pa;
   logic [3:0]  rsp_aci;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] fault_status, err_va_l1, err_va_l2;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   bit [31:0] mem [bit [31:0]];
   int        reads;
   bit [31:0] rd_log [4];

   localparam bit [31:0] BASE = 32'h0010_0000;

   always #4 clk = ~clk;

   iova_walker u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
      .rsp_pa(rsp_pa), .rsp_aci(rsp_aci), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .fault_status(fault_status), .err_va_l1(err_va_l1),
      .err_va_l2(err_va_l2), .irq(irq)
   );

   // memory model: answers one cycle after seeing a request
   always @(negedge clk) begin
      if (mem_valid) begin
         mem_valid <= 1'b0;
      end else if (mem_req) begin
         mem_valid <= 1'b1;
         mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
         if (reads < 4) rd_log[reads] = mem_addr;
         reads = reads + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // result of one request: edge count and outputs at the done pulse
   int        r_n;
   bit        r_ready1, r_fault;
   bit [31:0] r_pa;
   bit [3:0]  r_aci;

   task automatic translate(input logic [31:0] va);
      @(negedge clk);
      reads = 0;
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0;
      r_n = 1;
      r_ready1 = req_ready;
      while (!rsp_done && r_n < 40) begin
         @(negedge clk);
         r_n++;
      end
      r_fault = rsp_fault; r_pa = rsp_pa; r_aci = rsp_aci;
      @(negedge clk);
      chk(!rsp_done, "R9 done lasts one cycle", 32'(rsp_done), 32'h0);
   endtask

   function automatic bit [31:0] dir_addr(input bit [31:0] b, input bit [31:0] va);
      return b + {18'h0, va[31:20], 2'b00};
   endfunction
   function automatic bit [31:0] pte_addr(input bit [31:0] de, input bit [31:0] va);
      return {de[31:10], 10'h0} + {22'h0, va[19:12], 2'b00};
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
      chk(!rsp_done && !mem_req && !irq, "R1 idle outputs", {29'h0, rsp_done, mem_req, irq}, 32'h0);
      chk(fault_status == 0 && err_va_l1 == 0 && err_va_l2 == 0, "R1 status clear",
          fault_status | err_va_l1 | err_va_l2, 32'h0);
   endtask

   task automatic t_passthru();
      translate(32'hDEAD_BEEF);
      chk(r_n == 1, "R2 pass-through latency", 32'(r_n), 32'h1);
      chk(r_pa == 32'hDEAD_BEEF, "R2 pass-through address", r_pa, 32'hDEAD_BEEF);
      chk(!r_fault && r_aci == 0, "R2 no fault no index", {27'h0, r_fault, r_aci}, 32'h0);
      chk(reads == 0, "R2 no memory read", 32'(reads), 32'h0);
   endtask

   task automatic t_ignored_write();
      cfg_write(12'h030, 32'hFFFF_FFFF);
      translate(32'h1234_5678);
      chk(r_n == 1 && reads == 0 && r_pa == 32'h1234_5678, "R10 other offset leaves enable off",
          r_pa, 32'h1234_5678);
   endtask

   task automatic t_hit(input bit [31:0] va, input bit [31:0] de, input bit [31:0] pe);
      bit [31:0] exp_pa;
      mem[dir_addr(BASE, va)] = de;
      mem[pte_addr(de, va)]   = pe;
      exp_pa = {pe[31:12], va[11:0]};
      translate(va);
      chk(r_n == 4, "R9 walk latency", 32'(r_n), 32'h4);
      chk(!r_ready1, "R9 busy during walk", 32'(r_ready1), 32'h0);
      chk(reads == 2, "R6 two reads", 32'(reads), 32'h2);
      chk(rd_log[0] == dir_addr(BASE, va), "R3 directory address", rd_log[0], dir_addr(BASE, va));
      chk(rd_log[1] == pte_addr(de, va), "R5 second-level address", rd_log[1], pte_addr(de, va));
      chk(r_pa == exp_pa && !r_fault, "R6 translated address", r_pa, exp_pa);
      chk(r_aci == pe[7:4], "R6 access index", 32'(r_aci), 32'(pe[7:4]));
   endtask

   task automatic t_dir_fault(input bit [31:0] va, input bit [1:0] low, input bit [31:0] exp_err);
      mem[dir_addr(BASE, va)] = {24'h00A0_00, 6'h0, low};
      translate(va);
      chk(r_n == 2, "R9 first-level fault latency", 32'(r_n), 32'h2);
      chk(r_fault, "R4 fault reported", 32'(r_fault), 32'h1);
      chk(reads == 1, "R4 single read", 32'(reads), 32'h1);
      chk(fault_status == 32'h0001_0000 && irq, "R4 status bit 16", fault_status, 32'h0001_0000);
      chk(err_va_l1 == exp_err, "R11 first-level capture", err_va_l1, exp_err);
   endtask

   task automatic t_clear(input bit [31:0] d, input bit [31:0] exp_stat);
      cfg_write(12'h004, d);
      @(negedge clk);
      chk(fault_status == exp_stat, "R8 clear by write", fault_status, exp_stat);
      chk(irq == (exp_stat != 0), "R8 interrupt follows status", 32'(irq), 32'(exp_stat != 0));
   endtask

   task automatic t_pte_fault(input bit [31:0] va);
      bit [31:0] de = 32'h0040_0001;
      mem[dir_addr(BASE, va)] = de;
      mem[pte_addr(de, va)]   = 32'hFFFF_F0FD;
      translate(va);
      chk(r_n == 4 && r_fault && reads == 2, "R7 second-level fault", 32'(r_n), 32'h4);
      chk(fault_status == 32'h0002_0000 && irq, "R7 status bit 17 only", fault_status, 32'h0002_0000);
      chk(err_va_l2 == va, "R7 second-level capture", err_va_l2, va);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      reads = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_passthru();
      t_ignored_write();
      cfg_write(12'h050, BASE);
      cfg_write(12'h020, 32'h1);
      t_hit(32'h1234_5678, 32'h0020_0001, 32'hABCD_E0A2);
      t_hit(32'h2AB0_1FFF, 32'h0030_03FD, 32'h1234_5052);
      t_hit(32'hFFFF_F000, 32'h0050_0001, 32'h0000_1FF2);
      t_dir_fault(32'h7000_0111, 2'b00, 32'h7000_0111);
      t_dir_fault(32'h7010_0222, 2'b10, 32'h7000_0111);
      t_clear(32'h0001_0000, 32'h0);
      t_dir_fault(32'h7020_0333, 2'b11, 32'h7020_0333);
      t_clear(32'h0001_0000, 32'h0);
      t_pte_fault(32'h0801_2345);
      chk(err_va_l1 == 32'h7020_0333, "R7 first-level capture untouched", err_va_l1, 32'h7020_0333);
      t_clear(32'h0001_0000, 32'h0002_0000);
      t_clear(32'h0002_0000, 32'h0);
      cfg_write(12'h020, 32'h0);
      translate(32'h0BAD_F00D);
      chk(r_n == 1 && reads == 0 && r_pa == 32'h0BAD_F00D, "R10 enable cleared", r_pa, 32'h0BAD_F00D);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule